// File: doc/BRIEF.md
# I2C Bus Condition Front End

This block is the line-level stage of a two-wire serial slave. The raw clock and data lines enter it asynchronously. Each line is brought into a fast system clock domain, and pulses too short to be real bus activity are removed. From the cleaned lines the block reports bus events to the slave protocol engine as one-cycle strobes: a start, a stop, a sampled data bit with its value, and every falling edge of the serial clock.

In the other direction the engine asks for the data line to be pulled low. The block turns that request into an open-drain output enable. The enable can change only while the serial clock is low, and only after a fixed hold time has passed since the clock fell. This keeps a slave that is transmitting from creating a false start or stop while the falling clock edge is still unsettled.

The spike width and the hold time are given in nanoseconds, together with the system clock period. Cycle counts are derived from these values. Data bits are reported only between a start and the stop that closes the frame.

Top module: `i2c_cond_frontend`

## Requirements
- R1: While reset is high, and on the first cycle after it, every strobe output is 0 and the output enable `sda_oe_o` is 0 (line released). The filtered lines reset to the idle level, which is both lines high.
- R2: A falling data line while the clock line is high gives exactly one single-cycle `start_o` pulse. This holds both from idle and inside a frame (a repeated start).
- R3: A rising data line while the clock line is high gives exactly one single-cycle `stop_o` pulse.
- R4: Inside a frame, each rising clock edge gives one `bit_vld_o` pulse, with `bit_val_o` equal to the data line level at that edge. This includes the rising edge that comes just before a stop or repeated start.
- R5: A frame opens with a start and closes with a stop. Between a stop and the next start, clock pulses give no `bit_vld_o`.
- R6: A pulse on either line that lasts no longer than SPIKE_NS gives no event (5 system cycles or fewer at the default parameters). A level held for FILT_CYC = ceil(SPIKE_NS/CLK_NS)+1 cycles or more is accepted.
- R7: Every accepted falling edge of the clock line gives one `scl_fall_o` pulse, inside or outside a frame.
- R8: `sda_oe_o` never changes while the filtered clock line is high. After a clock fall it holds its value for at least HOLD_NS (HOLD_CYC = ceil(HOLD_NS/CLK_NS) cycles, counted from the filtered fall).
- R9: Once the clock line has been low past the hold window, `sda_oe_o` follows `sda_pull_req_i` on the next clock edge.
- R10: In any cycle, at most one of `start_o`, `stop_o`, `bit_vld_o`, `scl_fall_o` is high. A start strobe never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line |
| sda_pull_req_i | input | 1 | Engine request to pull the data line low |
| start_o | output | 1 | Start (or repeated start) strobe |
| stop_o | output | 1 | Stop strobe |
| bit_vld_o | output | 1 | Data bit sampled on a rising clock edge inside a frame |
| bit_val_o | output | 1 | Value of the last sampled data bit |
| scl_fall_o | output | 1 | Strobe on each filtered clock falling edge |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The bound checker checks four rules on every cycle. The event strobes never overlap. The output enable stays frozen while the filtered clock is high and through the whole hold window after each clock fall. Bit strobes appear only inside a frame. A start strobe is a single cycle. Some behaviour can only be shown by the bench scenarios, because it depends on what happens at the pins: the spike length at which the filter starts to accept a level, the exact bit values and event counts of whole frames, the repeated start, the hold delay measured from the raw clock pin, and the enable following a late request.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;

    // Index of each bus line inside the packed line vectors.
    localparam int unsigned LN_SCL  = 0;
    localparam int unsigned LN_SDA  = 1;
    localparam int unsigned N_LINES = 2;

    // Events reported to the protocol engine.
    typedef struct packed {
        logic start;
        logic stop;
        logic bit_vld;
        logic bit_val;
        logic scl_fall;
    } bus_evt_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // Consecutive stable cycles needed so that a spike of spike_ns is rejected.
    function automatic int unsigned filt_cycles(input int unsigned spike_ns, input int unsigned clk_ns);
        return ceil_div(spike_ns, clk_ns) + 1;
    endfunction

    // Cycles that cover the output hold time after a clock fall.
    function automatic int unsigned hold_cycles(input int unsigned hold_ns, input int unsigned clk_ns);
        return ceil_div(hold_ns, clk_ns);
    endfunction

endpackage

// File: rtl/i2c_fe_filter.sv
// Synchronizer followed by a persistence filter: the output takes a new level
// only after the synchronized input has shown it for FILT_CYC straight cycles.
module i2c_fe_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYC    = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic filt_o
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    logic [CW-1:0]          run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_o  <= 1'b1;
            run_cnt <= '0;
        end else if (synced == filt_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_CYC - 1)) begin
            filt_o  <= synced;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_fe_detect.sv
// Start/stop/bit/fall detection on the filtered lines, plus frame tracking.
module i2c_fe_detect
    import i2c_fe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output logic     scl_prev_o,
    output logic     in_frame_o,
    output bus_evt_t evt_o
);
    logic sda_prev;
    logic start_c;
    logic stop_c;
    logic rise_c;
    logic fall_c;

    always_comb begin
        start_c = scl_f & scl_prev_o & sda_prev & ~sda_f;
        stop_c  = scl_f & scl_prev_o & ~sda_prev & sda_f;
        rise_c  = scl_f & ~scl_prev_o;
        fall_c  = ~scl_f & scl_prev_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_o <= 1'b1;
            sda_prev   <= 1'b1;
            in_frame_o <= 1'b0;
            evt_o      <= '0;
        end else begin
            scl_prev_o     <= scl_f;
            sda_prev       <= sda_f;
            evt_o.start    <= start_c;
            evt_o.stop     <= stop_c;
            evt_o.bit_vld  <= rise_c & in_frame_o;
            evt_o.scl_fall <= fall_c;
            if (rise_c) begin
                evt_o.bit_val <= sda_f;
            end
            if (start_c) begin
                in_frame_o <= 1'b1;
            end else if (stop_c) begin
                in_frame_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_fe_sda_hold.sv
// Open-drain enable that follows the engine request only while the clock is
// settled low and HOLD_CYC cycles have passed since the last clock fall.
module i2c_fe_sda_hold #(
    parameter int unsigned HOLD_CYC = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic scl_prev,
    input  logic pull_req,
    output logic oe_o
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_cnt;
    logic          fall_c;

    assign fall_c = scl_prev & ~scl_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            oe_o     <= 1'b0;
        end else if (fall_c) begin
            hold_cnt <= HW'(HOLD_CYC);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else if (!scl_f && !scl_prev) begin
            oe_o <= pull_req;
        end
    end
endmodule

// File: rtl/i2c_cond_frontend.sv
module i2c_cond_frontend
    import i2c_fe_pkg::*;
#(
    parameter int unsigned CLK_NS      = 10,
    parameter int unsigned SPIKE_NS    = 50,
    parameter int unsigned HOLD_NS     = 300,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sda_pull_req_i,
    output logic start_o,
    output logic stop_o,
    output logic bit_vld_o,
    output logic bit_val_o,
    output logic scl_fall_o,
    output logic sda_oe_o
);
    localparam int unsigned FILT_CYC = filt_cycles(SPIKE_NS, CLK_NS);
    localparam int unsigned HOLD_CYC = hold_cycles(HOLD_NS, CLK_NS);

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_f;
    logic               sda_f;
    logic               scl_prev;
    logic               in_frame;
    bus_evt_t           evt;

    always_comb begin
        raw_lines         = '0;
        raw_lines[LN_SCL] = scl_i;
        raw_lines[LN_SDA] = sda_i;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_fe_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_CYC    (FILT_CYC)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[LN_SCL];
    assign sda_f = filt_lines[LN_SDA];

    i2c_fe_detect u_det (
        .clk        (clk),
        .rst        (rst),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .scl_prev_o (scl_prev),
        .in_frame_o (in_frame),
        .evt_o      (evt)
    );

    i2c_fe_sda_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (scl_f),
        .scl_prev (scl_prev),
        .pull_req (sda_pull_req_i),
        .oe_o     (sda_oe_o)
    );

    assign start_o    = evt.start;
    assign stop_o     = evt.stop;
    assign bit_vld_o  = evt.bit_vld;
    assign bit_val_o  = evt.bit_val;
    assign scl_fall_o = evt.scl_fall;
endmodule

// File: rtl/i2c_cond_frontend_chk.sv
module i2c_cond_frontend_chk #(
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned HOLD_NS = 300
) (
    input logic clk,
    input logic rst,
    input logic start_o,
    input logic stop_o,
    input logic bit_vld_o,
    input logic scl_fall_o,
    input logic sda_oe_o,
    input logic scl_filt,
    input logic in_frame
);
    localparam int unsigned HOLD_CYC = i2c_fe_pkg::hold_cycles(HOLD_NS, CLK_NS);
    localparam int unsigned HW       = $clog2(HOLD_CYC + 2);

    // Window counter that covers the hold period after each reported fall.
    logic [HW-1:0] win_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (scl_fall_o) begin
            win_cnt <= HW'(HOLD_CYC);
        end else if (win_cnt != '0) begin
            win_cnt <= win_cnt - 1'b1;
        end
    end

    p_evt_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_o, stop_o, bit_vld_o, scl_fall_o}));

    p_start_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

    p_oe_frozen_high_r8: assert property (@(posedge clk) disable iff (rst)
        (scl_filt && $past(scl_filt)) |-> $stable(sda_oe_o));

    p_oe_hold_window_r8: assert property (@(posedge clk) disable iff (rst)
        (scl_fall_o || win_cnt != '0) |-> $stable(sda_oe_o));

    p_bit_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |-> in_frame);
endmodule

bind i2c_cond_frontend i2c_cond_frontend_chk #(
    .CLK_NS  (CLK_NS),
    .HOLD_NS (HOLD_NS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .bit_vld_o  (bit_vld_o),
    .scl_fall_o (scl_fall_o),
    .sda_oe_o   (sda_oe_o),
    .scl_filt   (scl_f),
    .in_frame   (in_frame)
);

// File: tb/tb_i2c_cond_frontend.sv
module tb_i2c_cond_frontend;
    localparam int CLK_NS   = 10;
    localparam int FILT_CYC = (50 + CLK_NS - 1) / CLK_NS + 1;
    localparam int HOLD_CYC = (300 + CLK_NS - 1) / CLK_NS;
    localparam int T_LOW    = 130;
    localparam int T_HIGH   = 60;

    // {bit count, data}: bits are sent MSB first from data[nbits-1].
    localparam logic [11:0] VECS [0:3] = '{
        {4'd8, 8'hA5}, {4'd8, 8'h3C}, {4'd5, 8'h16}, {4'd1, 8'h01}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic req = 1'b0;
    logic start_o, stop_o, bit_vld_o, bit_val_o, scl_fall_o, sda_oe_o;

    int n_start = 0, n_stop = 0, n_bit = 0, n_fall = 0;
    logic [15:0] cap = '0;
    int checks = 0, errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    i2c_cond_frontend dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_pull_req_i(req),
        .start_o(start_o), .stop_o(stop_o), .bit_vld_o(bit_vld_o),
        .bit_val_o(bit_val_o), .scl_fall_o(scl_fall_o), .sda_oe_o(sda_oe_o)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (start_o)    n_start <= n_start + 1;
            if (stop_o)     n_stop  <= n_stop + 1;
            if (scl_fall_o) n_fall  <= n_fall + 1;
            if (bit_vld_o) begin
                n_bit <= n_bit + 1;
                cap   <= {cap[14:0], bit_val_o};
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b0; wcyc(T_HIGH);
        scl = 1'b0; wcyc(30);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    wcyc(T_LOW - 30);
        scl = 1'b1; wcyc(T_HIGH);
        scl = 1'b0; wcyc(30);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wcyc(T_LOW - 30);
        scl = 1'b1; wcyc(T_HIGH);
        sda = 1'b1; wcyc(T_LOW);
    endtask

    task automatic bus_rstart();
        sda = 1'b1; wcyc(T_LOW - 30);
        scl = 1'b1; wcyc(T_HIGH);
        sda = 1'b0; wcyc(T_HIGH);
        scl = 1'b0; wcyc(30);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int s0, p0, b0, f0, c;
        // R1: reset state
        wcyc(5);
        chk("R1 strobes in reset", {start_o, stop_o, bit_vld_o, scl_fall_o}, 0);
        chk("R1 oe in reset", sda_oe_o, 0);
        rst = 1'b0;
        wcyc(1);
        chk("R1 strobes after reset", {start_o, stop_o, bit_vld_o, scl_fall_o}, 0);
        chk("R1 oe after reset", sda_oe_o, 0);
        wcyc(20);

        // Vector table: whole frames (R2, R3, R4, R7)
        for (int i = 0; i < 4; i++) begin
            int nb;
            logic [7:0] d;
            logic [15:0] mask;
            nb = int'(VECS[i][11:8]);
            d  = VECS[i][7:0];
            mask = (16'd1 << nb) - 16'd1;
            s0 = n_start; p0 = n_stop; b0 = n_bit; f0 = n_fall;
            bus_start();
            for (int k = nb - 1; k >= 0; k--) bus_bit(d[k]);
            bus_stop();
            chk("R2 start count", n_start - s0, 1);
            chk("R3 stop count", n_stop - p0, 1);
            chk("R4 bit count", n_bit - b0, nb + 1);
            chk("R4 bit values", int'((cap >> 1) & mask), int'({8'd0, d} & mask));
            chk("R7 fall count", n_fall - f0, nb + 1);
        end

        // R5: clock pulses between stop and next start give no bits
        s0 = n_start; b0 = n_bit; f0 = n_fall;
        for (int k = 0; k < 3; k++) begin
            scl = 1'b0; wcyc(T_LOW);
            scl = 1'b1; wcyc(T_HIGH);
        end
        chk("R5 no bits outside frame", n_bit - b0, 0);
        chk("R5 no start without sda edge", n_start - s0, 0);
        chk("R7 falls outside frame", n_fall - f0, 3);

        // R2: repeated start inside a frame keeps the frame open
        s0 = n_start; p0 = n_stop; b0 = n_bit;
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_rstart();
        bus_bit(1'b1);
        bus_stop();
        chk("R2 repeated start count", n_start - s0, 2);
        chk("R3 single stop after repeated start", n_stop - p0, 1);
        chk("R4 bits across repeated start", n_bit - b0, 6);

        // R6: data spike of SPIKE length while idle is rejected
        s0 = n_start; p0 = n_stop;
        sda = 1'b0; wcyc(FILT_CYC - 1); sda = 1'b1; wcyc(40);
        chk("R6 short sda spike no start", n_start - s0, 0);
        chk("R6 short sda spike no stop", n_stop - p0, 0);
        // R6: a pulse of FILT_CYC cycles is accepted
        sda = 1'b0; wcyc(FILT_CYC + 1); sda = 1'b1; wcyc(40);
        chk("R6 long sda pulse start", n_start - s0, 1);
        chk("R6 long sda pulse stop", n_stop - p0, 1);

        // R6: clock spike inside a frame is rejected
        bus_start();
        b0 = n_bit; f0 = n_fall;
        wcyc(40);
        scl = 1'b1; wcyc(FILT_CYC - 1); scl = 1'b0; wcyc(60);
        chk("R6 short scl spike no bit", n_bit - b0, 0);
        chk("R6 short scl spike no fall", n_fall - f0, 0);

        // R8: request during clock high does not move oe
        sda = 1'b1; wcyc(T_LOW - 30);
        scl = 1'b1; wcyc(10);
        req = 1'b1; wcyc(40);
        chk("R8 oe frozen while scl high", sda_oe_o, 0);
        // R8: oe moves no earlier than the hold time after the pin falls
        scl = 1'b0;
        c = 0;
        while (!sda_oe_o && c < 200) begin
            @(negedge clk);
            c++;
        end
        chk("R8 hold not shorter than HOLD_NS", int'(c >= HOLD_CYC), 1);
        chk("R8 hold bounded", int'(c <= HOLD_CYC + FILT_CYC + 6), 1);
        // R9: late request follows on the next edge
        wcyc(60);
        req = 1'b0; wcyc(2);
        chk("R9 oe follows late request", sda_oe_o, 0);
        req = 1'b1; wcyc(2);
        chk("R9 oe follows late request again", sda_oe_o, 1);
        req = 1'b0; wcyc(2);
        bus_stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule